// File: doc/BRIEF.md
# Ping-pong SRAM acquisition arbiter

This block sits between a processor bus, one single-port SRAM, an incoming ADC sample strobe and an outgoing DAC sample handshake. The SRAM address space is cut into four equal quarters by its two top address bits. Physical quarter 0 is a general-purpose area and quarter 1 is a transmit waveform buffer. Quarters 2 and 3 are two receive buffers, A and B. While the processor runs, the block moves ADC samples into whichever receive buffer is filling. It also streams the transmit buffer to the DAC over and over. Both transfers use only the cycles in which the processor is not touching the SRAM.

The processor sees one receive window at its quarter 2. The block points that window at the receive buffer that completed most recently. When a buffer fills, the two buffers swap roles and an interrupt is raised. Processor quarter 3 holds a small status and clear register in place of SRAM. The SRAM is modelled as a port that takes one access per cycle, and read data returns on the following cycle.

Top module: `spp_arbiter`

## Requirements
- R1: After reset, irq is 0 and the status register reads 0. Buffer A is the filling buffer, so the receive window reads physical quarter 3 (buffer B).
- R2: A processor access to address quarters 0 or 1 (top bits 00 or 01) drives the same address to the SRAM in that same cycle. A read returns its data with cpu_rvalid high on the next cycle.
- R3: Any cycle in which the processor accesses the SRAM belongs to the processor. DMA transfers take only the remaining cycles, and a pending ADC write goes before a pending DAC read.
- R4: ADC samples are written to the filling buffer at offsets 0, 1, 2 and up, in arrival order. Buffer A is physical quarter 2 and buffer B is physical quarter 3.
- R5: Writing offset RX_LEN-1 completes the buffer. The fill and ready roles then swap, irq rises, and processor reads of quarter 2 are translated to the completed buffer at the same offset.
- R6: Processor writes to quarter 2 (the receive window) change no SRAM word.
- R7: A read of quarter 3 returns {dropped, overrun, irq} in bits 2:0, with zeros above. A write to quarter 3 with bit 0 set clears irq, and with bit 1 set clears overrun and dropped.
- R8: When a buffer completes while irq is still set and not being cleared in that cycle, the sticky overrun flag is set.
- R9: When a sample arrives while the previous one is still held and is not written in that cycle, the new sample is discarded and the sticky dropped flag is set. The held sample is still written.
- R10: The DAC receives transmit-quarter words at offsets 0 to TX_LEN-1 in order, then starts again at 0. dac_data stays stable while dac_valid is high and dac_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, one cycle |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after request |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | AW | SRAM physical address |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM read data, one cycle after a read |
| adc_valid | input | 1 | New ADC sample strobe |
| adc_data | input | DW | ADC sample |
| dac_valid | output | 1 | DAC word available |
| dac_ready | input | 1 | DAC accepts the word |
| dac_data | output | DW | DAC word |
| irq | output | 1 | Receive buffer ready interrupt |

## Verification
A wrong fill or ready selector would show as soon as the receive window is read. The read would return stale or mixed samples on the cycle after the request, or an ADC write would land in the quarter the processor is reading. A fill pointer that is off by one would move the interrupt edge by one sample and scatter the samples across the wrong offsets, which window reads show directly. A wrong transmit pointer would break the cyclic DAC sequence at the first wrap. A flag error appears on the next status read.

// File: rtl/spp_pkg.sv
package spp_pkg;
   typedef enum logic [1:0] {
      REG_GEN  = 2'd0,
      REG_TX   = 2'd1,
      REG_RXW  = 2'd2,
      REG_CTRL = 2'd3
   } cpu_region_e;

   localparam int ST_W = 3;
endpackage

// File: rtl/spp_addr_map.sv
module spp_addr_map
   import spp_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_we,
   input  logic          ready_sel,
   output cpu_region_e   region,
   output logic [AW-1:0] phys_addr,
   output logic          sram_hit
);
   localparam int OFF_W = AW - 2;

   always_comb begin
      region    = cpu_region_e'(cpu_addr[AW-1 -: 2]);
      phys_addr = cpu_addr;
      sram_hit  = 1'b0;
      unique case (region)
         REG_GEN, REG_TX: sram_hit = 1'b1;
         REG_RXW: begin
            phys_addr = {1'b1, ready_sel, cpu_addr[OFF_W-1:0]};
            sram_hit  = !cpu_we;
         end
         default: sram_hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/spp_rx_fill.sv
module spp_rx_fill #(
   parameter int DW     = 16,
   parameter int OFF_W  = 6,
   parameter int RX_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adc_valid,
   input  logic [DW-1:0]    adc_data,
   input  logic             wr_go,
   input  logic             irq_clr,
   input  logic             flag_clr,
   output logic             wr_req,
   output logic [DW-1:0]    wr_data,
   output logic [OFF_W-1:0] wr_off,
   output logic             fill_sel,
   output logic             irq,
   output logic             overrun,
   output logic             dropped
);
   logic             full_q, fill_q, irq_q, ovr_q, drop_q;
   logic [DW-1:0]    hold_q;
   logic [OFF_W-1:0] ptr_q;
   logic             last, swap;

   assign last = (ptr_q == OFF_W'(RX_LEN - 1));
   assign swap = wr_go && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= '0;
         ptr_q  <= '0;
         fill_q <= 1'b0;
         irq_q  <= 1'b0;
         ovr_q  <= 1'b0;
         drop_q <= 1'b0;
      end else begin
         if (wr_go) ptr_q <= last ? '0 : ptr_q + OFF_W'(1);
         if (swap) fill_q <= ~fill_q;
         if (adc_valid && (!full_q || wr_go)) begin
            hold_q <= adc_data;
            full_q <= 1'b1;
         end else if (wr_go) begin
            full_q <= 1'b0;
         end
         if (adc_valid && full_q && !wr_go) drop_q <= 1'b1;
         else if (flag_clr)                 drop_q <= 1'b0;
         if (swap)         irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
         if (swap && irq_q && !irq_clr) ovr_q <= 1'b1;
         else if (flag_clr)             ovr_q <= 1'b0;
      end
   end

   assign wr_req   = full_q;
   assign wr_data  = hold_q;
   assign wr_off   = ptr_q;
   assign fill_sel = fill_q;
   assign irq      = irq_q;
   assign overrun  = ovr_q;
   assign dropped  = drop_q;

   // R5: a new interrupt only appears together with a buffer swap
   a_r5_irq_marks_swap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> (fill_q != $past(fill_q)));
   // R9: the dropped flag can only rise while a sample was held
   a_r9_drop_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drop_q) |-> $past(full_q));
   // R4: sequential fill offsets
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && !last) |=> (ptr_q == $past(ptr_q) + OFF_W'(1)));
   // R8: overrun rises only when a swap meets a pending interrupt
   a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> ($past(irq_q) && $past(wr_go)));
endmodule

// File: rtl/spp_tx_fetch.sv
module spp_tx_fetch #(
   parameter int DW     = 16,
   parameter int OFF_W  = 6,
   parameter int TX_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_go,
   input  logic [DW-1:0]    sram_rdata,
   input  logic             dac_ready,
   output logic             rd_req,
   output logic [OFF_W-1:0] rd_off,
   output logic             dac_valid,
   output logic [DW-1:0]    dac_data
);
   logic             full_q, infl_q, last;
   logic [DW-1:0]    data_q;
   logic [OFF_W-1:0] ptr_q;

   assign last = (ptr_q == OFF_W'(TX_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         infl_q <= 1'b0;
         data_q <= '0;
         ptr_q  <= '0;
      end else begin
         infl_q <= rd_go;
         if (rd_go) ptr_q <= last ? '0 : ptr_q + OFF_W'(1);
         if (infl_q) begin
            data_q <= sram_rdata;
            full_q <= 1'b1;
         end else if (full_q && dac_ready) begin
            full_q <= 1'b0;
         end
      end
   end

   assign rd_req    = !full_q && !infl_q;
   assign rd_off    = ptr_q;
   assign dac_valid = full_q;
   assign dac_data  = data_q;

   // R10: an offered word is held until taken
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !dac_ready) |=> (full_q && $stable(data_q)));
   // R10: the read pointer wraps after the last transmit word
   a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && last) |=> (ptr_q == '0));
endmodule

// File: rtl/spp_arbiter.sv
module spp_arbiter
   import spp_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DW        = 16,
   parameter int RX_LEN    = 4,
   parameter int TX_LEN    = 3,
   parameter bit ADC_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_rvalid,
   output logic          sram_en,
   output logic          sram_we,
   output logic [AW-1:0] sram_addr,
   output logic [DW-1:0] sram_wdata,
   input  logic [DW-1:0] sram_rdata,
   input  logic          adc_valid,
   input  logic [DW-1:0] adc_data,
   output logic          dac_valid,
   input  logic          dac_ready,
   output logic [DW-1:0] dac_data,
   output logic          irq
);
   localparam int OFF_W = AW - 2;

   initial begin
      assert (AW >= 3) else $error("AW too small");
      assert (DW >= ST_W) else $error("DW must hold the status bits");
      assert (RX_LEN >= 2 && RX_LEN <= (1 << OFF_W)) else $error("RX_LEN out of range");
      assert (TX_LEN >= 1 && TX_LEN <= (1 << OFF_W)) else $error("TX_LEN out of range");
   end

   cpu_region_e      region;
   logic [AW-1:0]    cpu_phys;
   logic             cpu_hit, cpu_sram, slot_free;
   logic             wr_req, wr_go, rd_req, rd_go;
   logic [DW-1:0]    wr_data;
   logic [OFF_W-1:0] wr_off, rd_off;
   logic             fill_sel, overrun, dropped;
   logic             ctrl_wr, irq_clr, flag_clr;
   logic             rvalid_q, rd_ctrl_q;
   logic [ST_W-1:0]  status_q;

   spp_addr_map #(.AW(AW)) u_map (
      .cpu_addr (cpu_addr),
      .cpu_we   (cpu_we),
      .ready_sel(~fill_sel),
      .region   (region),
      .phys_addr(cpu_phys),
      .sram_hit (cpu_hit)
   );

   assign cpu_sram  = cpu_req && cpu_hit;
   assign slot_free = !cpu_sram;

   generate
      if (ADC_FIRST) begin : g_adc_first
         assign wr_go = slot_free && wr_req;
         assign rd_go = slot_free && rd_req && !wr_req;
      end else begin : g_dac_first
         assign rd_go = slot_free && rd_req;
         assign wr_go = slot_free && wr_req && !rd_req;
      end
   endgenerate

   assign ctrl_wr  = cpu_req && cpu_we && (region == REG_CTRL);
   assign irq_clr  = ctrl_wr && cpu_wdata[0];
   assign flag_clr = ctrl_wr && cpu_wdata[1];

   spp_rx_fill #(.DW(DW), .OFF_W(OFF_W), .RX_LEN(RX_LEN)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .adc_valid(adc_valid),
      .adc_data (adc_data),
      .wr_go    (wr_go),
      .irq_clr  (irq_clr),
      .flag_clr (flag_clr),
      .wr_req   (wr_req),
      .wr_data  (wr_data),
      .wr_off   (wr_off),
      .fill_sel (fill_sel),
      .irq      (irq),
      .overrun  (overrun),
      .dropped  (dropped)
   );

   spp_tx_fetch #(.DW(DW), .OFF_W(OFF_W), .TX_LEN(TX_LEN)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_go     (rd_go),
      .sram_rdata(sram_rdata),
      .dac_ready (dac_ready),
      .rd_req    (rd_req),
      .rd_off    (rd_off),
      .dac_valid (dac_valid),
      .dac_data  (dac_data)
   );

   always_comb begin
      sram_en    = 1'b0;
      sram_we    = 1'b0;
      sram_addr  = '0;
      sram_wdata = '0;
      if (cpu_sram) begin
         sram_en    = 1'b1;
         sram_we    = cpu_we;
         sram_addr  = cpu_phys;
         sram_wdata = cpu_wdata;
      end else if (wr_go) begin
         sram_en    = 1'b1;
         sram_we    = 1'b1;
         sram_addr  = {1'b1, fill_sel, wr_off};
         sram_wdata = wr_data;
      end else if (rd_go) begin
         sram_en    = 1'b1;
         sram_addr  = {2'b01, rd_off};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q  <= 1'b0;
         rd_ctrl_q <= 1'b0;
         status_q  <= '0;
      end else begin
         rvalid_q  <= cpu_req && !cpu_we && (cpu_hit || region == REG_CTRL);
         rd_ctrl_q <= cpu_req && !cpu_we && (region == REG_CTRL);
         status_q  <= {dropped, overrun, irq};
      end
   end

   assign cpu_rvalid = rvalid_q;
   assign cpu_rdata  = rd_ctrl_q ? {{(DW-ST_W){1'b0}}, status_q} : sram_rdata;

   // R5: reads of a receive quarter never target the filling buffer
   a_r5_window_reads_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_en && !sram_we && sram_addr[AW-1]) |-> (sram_addr[AW-2] != fill_sel));
   // R6/R4: the only writes into receive quarters go to the filling buffer
   a_r6_rx_writes_fill_only: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_en && sram_we && sram_addr[AW-1]) |-> (sram_addr[AW-2] == fill_sel));
   // R2: a processor SRAM read returns on the next cycle
   a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && cpu_hit) |=> cpu_rvalid);
endmodule

// File: tb/tb_spp_arbiter.sv
`timescale 1ns/1ps
module tb_spp_arbiter;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_rvalid;
   logic          sram_en, sram_we;
   logic [AW-1:0] sram_addr;
   logic [DW-1:0] sram_wdata;
   logic [DW-1:0] sram_rdata = '0;
   logic          adc_valid = 1'b0;
   logic [DW-1:0] adc_data = '0;
   logic          dac_valid;
   logic          dac_ready = 1'b0;
   logic [DW-1:0] dac_data;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] mem [256];

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (sram_en) begin
         if (sram_we) mem[sram_addr] <= sram_wdata;
         else         sram_rdata     <= mem[sram_addr];
      end
   end

   spp_arbiter #(.AW(AW), .DW(DW), .RX_LEN(4), .TX_LEN(3), .ADC_FIRST(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
      .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
      .adc_valid(adc_valid), .adc_data(adc_data),
      .dac_valid(dac_valid), .dac_ready(dac_ready), .dac_data(dac_data),
      .irq(irq)
   );

   // {we, addr, data}: data is write data or expected read data
   localparam logic [24:0] VECS [8] = '{
      {1'b1, 8'h05, 16'h1234},
      {1'b1, 8'h3F, 16'hBEEF},
      {1'b1, 8'h50, 16'h5A5A},
      {1'b0, 8'h05, 16'h1234},
      {1'b0, 8'h3F, 16'hBEEF},
      {1'b0, 8'h50, 16'h5A5A},
      {1'b1, 8'h05, 16'h0F0F},
      {1'b0, 8'h05, 16'h0F0F}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic cpu_read_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      cpu_op(1'b0, a, '0);
      chk({tag, " rvalid"}, cpu_rvalid, 1);
      chk(tag, cpu_rdata, exp);
      idle(1);
   endtask

   task automatic adc_push(input logic [DW-1:0] d);
      adc_valid = 1'b1; adc_data = d;
      @(negedge clk);
      adc_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      mem[8'h40] = 16'h00A0; mem[8'h41] = 16'h00A1; mem[8'h42] = 16'h00A2;
      mem[8'h80] = 16'hA0A0; mem[8'hC0] = 16'hB0B0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 irq", irq, 0);
      chk("R1 rvalid", cpu_rvalid, 0);
      cpu_read_chk("R1 status", 8'hC0, 16'h0000);
      cpu_read_chk("R1 window maps to B", 8'h80, 16'hB0B0);

      // R2/R3 pass-through table
      for (int i = 0; i < 8; i++) begin
         cpu_req = 1'b1; cpu_we = VECS[i][24]; cpu_addr = VECS[i][23:16];
         cpu_wdata = VECS[i][24] ? VECS[i][15:0] : '0;
         #1;
         chk("R2 sram_addr", sram_addr, VECS[i][23:16]);
         chk("R3 cpu owns slot", {sram_en, sram_we}, {1'b1, VECS[i][24]});
         @(negedge clk);
         cpu_req = 1'b0; cpu_we = 1'b0;
         if (!VECS[i][24]) begin
            chk("R2 rvalid", cpu_rvalid, 1);
            chk("R2 rdata", cpu_rdata, VECS[i][15:0]);
         end
         idle(1);
      end

      // R10 hold while not ready
      chk("R10 held valid", dac_valid, 1);
      chk("R10 held data", dac_data, 16'h00A0);

      // R4/R5 first buffer into A
      for (int i = 0; i < 3; i++) adc_push(16'h1100 + 16'(i));
      chk("R5 no irq before last", irq, 0);
      adc_push(16'h1103);
      chk("R5 irq after fill", irq, 1);
      for (int i = 0; i < 4; i++) chk("R4 buffer A word", mem[8'h80 + i], 16'h1100 + 16'(i));
      cpu_read_chk("R5 window offset0", 8'h80, 16'h1100);
      cpu_read_chk("R5 window offset3", 8'h83, 16'h1103);
      cpu_read_chk("R7 status irq", 8'hC0, 16'h0001);

      // R6 writes to the window are ignored
      cpu_op(1'b1, 8'h81, 16'hDEAD);
      idle(1);
      chk("R6 buffer A untouched", mem[8'h81], 16'h1101);
      chk("R6 buffer B untouched", mem[8'hC1], 16'h0000);
      cpu_read_chk("R6 window unchanged", 8'h81, 16'h1101);

      // R7 clear interrupt
      cpu_op(1'b1, 8'hC0, 16'h0001);
      idle(1);
      chk("R7 irq cleared", irq, 0);
      cpu_read_chk("R7 status clear", 8'hC0, 16'h0000);

      // R4/R5 second buffer into B
      for (int i = 0; i < 4; i++) adc_push(16'h2200 + 16'(i));
      chk("R5 irq second", irq, 1);
      chk("R4 buffer B word", mem[8'hC2], 16'h2202);
      cpu_read_chk("R5 window now B", 8'h82, 16'h2202);

      // R8 third buffer while irq pending
      for (int i = 0; i < 4; i++) adc_push(16'h3300 + 16'(i));
      cpu_read_chk("R8 status overrun", 8'hC0, 16'h0003);
      cpu_read_chk("R5 window back to A", 8'h81, 16'h3301);

      // R9 drop: second sample arrives while processor owns the slot
      adc_valid = 1'b1; adc_data = 16'h4400;
      @(negedge clk);
      adc_data = 16'h4401;
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h05;
      #1;
      chk("R3 cpu wins over pending ADC", {sram_en, sram_we, sram_addr}, {1'b1, 1'b0, 8'h05});
      @(negedge clk);
      adc_valid = 1'b0; cpu_req = 1'b0;
      idle(2);
      chk("R9 held sample written", mem[8'hC0], 16'h4400);
      chk("R9 later sample discarded", mem[8'hC1], 16'h2201);
      cpu_read_chk("R9 status dropped", 8'hC0, 16'h0007);
      cpu_op(1'b1, 8'hC0, 16'h0003);
      idle(1);
      cpu_read_chk("R7 all cleared", 8'hC0, 16'h0000);

      // R10 cyclic DAC stream
      for (int k = 0; k < 7; k++) begin
         for (int w = 0; w < 10 && !dac_valid; w++) @(negedge clk);
         chk("R10 dac word", dac_data, 16'h00A0 + 16'(k % 3));
         dac_ready = 1'b1;
         @(negedge clk);
         dac_ready = 1'b0;
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule